// File: doc/BRIEF.md
# Four-Channel Double-Buffered Serial Converter Front End

This block is the digital side of a four-channel current-output converter. A host writes 18-bit frames over a three-wire serial link made of an active-low select, a serial clock and a data line. Each frame carries a 2-bit channel number and a 14-bit code. When the select line returns high, the block decodes the most recent 18 bits and stores the code in the input register of the addressed channel.

A separate active-low, level-sensitive load line copies all four input registers into the four converter registers at once. The converter registers drive the analog ladders outside this block. An asynchronous active-low preset forces every input and converter register to zero code or to half-scale code. A select pin picks which of the two. The synchronous system reset applies the same preset, as a power-up would.

The serial lines and the load line are synchronized into the system clock domain. A serial output taken from the last shift stage lets several devices be chained on one link.

Top module: `qdac_serial_front`

## Requirements
- R1: After the synchronous reset `rst_n` is released, every converter output holds the preset code (0x2000 when `half_sel`=1, 0x0000 when `half_sel`=0) and `ser_dout` is 0.
- R2: A frame is shifted most significant bit first as `{addr[1:0], pad[1:0], code[13:0]}`. Address 0 writes channel 0 (bits 13:0 of `dac_codes`), 1 writes channel 1 (bits 27:14), 2 writes channel 2 (bits 41:28) and 3 writes channel 3 (bits 55:42). The pad bits have no effect.
- R3: Rising `ser_clk` edges while `ser_csn` is high do not change the shift register. `ser_dout` stays constant, and a later partial frame builds on the unchanged contents.
- R4: When more than 18 bits are shifted in one select-low window, only the last 18 are decoded on the rising edge of `ser_csn`.
- R5: While `load_n` is high, the converter outputs hold, even when an input register is written.
- R6: While `load_n` is low, each converter register follows its input register. A write committed during this time reaches the output one system clock after the input register changes.
- R7: While `preset_n` is low, every input and converter register is forced at once, without waiting for a clock, to 0x2000 if `half_sel`=1 or to 0x0000 if `half_sel`=0. After release the outputs keep that value until a write is followed by a load.
- R8: `ser_dout` shows the oldest of the 18 shift stages, so a bit shifted in appears at `ser_dout` after 18 rising serial-clock edges.
- R9: A frame of fewer than 18 bits is still committed from the shift register as it stands: the older stored bits are shifted up by the number of new bits.
- R10: A load pulse in the middle of a frame copies the input registers and does not disturb the shifting in progress.
- R11: A commit changes at most one input register, the one named by the address bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset, applies the preset code |
| preset_n | input | 1 | Asynchronous active-low preset of all input and converter registers |
| half_sel | input | 1 | Preset value select: 1 gives half-scale, 0 gives zero |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_csn | input | 1 | Active-low select; its rising edge commits the frame |
| ser_din | input | 1 | Serial data in, most significant bit first |
| load_n | input | 1 | Active-low, level-sensitive transfer of input registers to converter registers |
| ser_dout | output | 1 | Oldest shift stage, used for daisy chaining |
| dac_codes | output | 56 | Four 14-bit converter register values; channel n occupies bits 14n+13:14n |

## Verification
A frame commit into an input register and the transparent load into the converter registers can fall in the same cycle. The bench provokes this by holding `load_n` low while it raises `ser_csn`, so the converter register must take the newly written value one clock after the input register and must never show a stale value afterwards. It also pulses the load line in the middle of a frame, so that the load and the shifting overlap. Each case is judged against a bench-side model of the shift register, the input registers and the converter registers, and all four channel outputs are compared after every step.

// File: rtl/qdac_pkg.sv
// Shared constants and helpers for the four-channel serial converter front end.
package qdac_pkg;
    localparam int CODE_W      = 14;
    localparam int ADDR_W      = 2;
    localparam int GAP_W       = 2;
    localparam int SYNC_STAGES = 2;

    // Preset code: half-scale sets only the top code bit, otherwise zero.
    function automatic logic [CODE_W-1:0] preset_code(input logic half);
        return half ? {1'b1, {(CODE_W-1){1'b0}}} : '0;
    endfunction
endpackage

// File: rtl/qdac_sync.sv
// Multi-stage synchronizer for a bus of independent asynchronous levels.
// Assumes each bit is a slow level; no bus coherency is implied.
module qdac_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [STAGES-1:0][W-1:0] stg;

    // Shift each level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) stg <= {STAGES{RST_VAL}};
        else        stg <= {stg[STAGES-2:0], async_i};
    end

    assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/qdac_shifter.sv
// Serial frame shift register. Shifts one bit per enable pulse, LSB side in.
// Exposes the address and code fields of the newest frame and the oldest stage.
module qdac_shifter #(
    parameter int ADDR_W = 2,
    parameter int GAP_W  = 2,
    parameter int CODE_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              bit_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic [CODE_W-1:0] code_o,
    output logic              dout_o
);
    localparam int FRAME_W = ADDR_W + GAP_W + CODE_W;

    logic [FRAME_W-1:0] sr;

    // Advance the frame register on each detected serial clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        sr <= '0;
        else if (shift_en) sr <= {sr[FRAME_W-2:0], bit_i};
    end

    assign addr_o = sr[FRAME_W-1 -: ADDR_W];
    assign code_o = sr[CODE_W-1:0];
    assign dout_o = sr[FRAME_W-1];
endmodule

// File: rtl/qdac_chan_bank.sv
// Input and converter register pairs for every channel.
// Preset is asynchronous; the system reset applies the same preset synchronously.
module qdac_chan_bank #(
    parameter int CODE_W = 14,
    parameter int ADDR_W = 2,
    parameter int NUM_CH = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     preset_n,
    input  logic                     half_sel,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [CODE_W-1:0]        wr_code,
    input  logic                     load_n,
    output logic [NUM_CH*CODE_W-1:0] in_flat,
    output logic [NUM_CH*CODE_W-1:0] dac_flat
);
    logic [CODE_W-1:0] pv;
    assign pv = qdac_pkg::preset_code(half_sel);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        logic [CODE_W-1:0] in_q;
        logic [CODE_W-1:0] dac_q;

        // Input register: written by a commit addressed to this channel.
        always_ff @(posedge clk or negedge preset_n) begin
            if (!preset_n)                                 in_q <= pv;
            else if (!rst_n)                               in_q <= pv;
            else if (wr_en && (wr_addr == ADDR_W'(ch)))    in_q <= wr_code;
        end

        // Converter register: transparent copy of the input register while load is low.
        always_ff @(posedge clk or negedge preset_n) begin
            if (!preset_n)    dac_q <= pv;
            else if (!rst_n)  dac_q <= pv;
            else if (!load_n) dac_q <= in_q;
        end

        assign in_flat[ch*CODE_W +: CODE_W]  = in_q;
        assign dac_flat[ch*CODE_W +: CODE_W] = dac_q;
    end
endmodule

// File: rtl/qdac_serial_front.sv
// Top of the four-channel serial converter front end.
// Synchronizes the serial link and load line into clk, detects serial clock and
// select edges, shifts frames, commits on select rising and drives the
// double-buffered channel registers. Assumes clk is several times faster than ser_clk.
module qdac_serial_front #(
    parameter int CODE_W      = qdac_pkg::CODE_W,
    parameter int ADDR_W      = qdac_pkg::ADDR_W,
    parameter int GAP_W       = qdac_pkg::GAP_W,
    parameter int SYNC_STAGES = qdac_pkg::SYNC_STAGES
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          preset_n,
    input  logic                          half_sel,
    input  logic                          ser_clk,
    input  logic                          ser_csn,
    input  logic                          ser_din,
    input  logic                          load_n,
    output logic                          ser_dout,
    output logic [(1<<ADDR_W)*CODE_W-1:0] dac_codes
);
    localparam int NUM_CH = 1 << ADDR_W;

    logic [3:0]              sync_bus;
    logic                    load_s, csn_s, sclk_s, din_s;
    logic                    sclk_q, csn_q;
    logic                    shift_en, commit;
    logic [ADDR_W-1:0]       wr_addr;
    logic [CODE_W-1:0]       wr_code;
    logic [NUM_CH*CODE_W-1:0] in_flat;

    qdac_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1100)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({load_n, ser_csn, ser_clk, ser_din}),
        .sync_o  (sync_bus)
    );
    assign {load_s, csn_s, sclk_s, din_s} = sync_bus;

    // Keep the previous synchronized clock and select for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            csn_q  <= 1'b1;
        end else begin
            sclk_q <= sclk_s;
            csn_q  <= csn_s;
        end
    end

    assign shift_en = sclk_s & ~sclk_q & ~csn_s;
    assign commit   = csn_s & ~csn_q;

    qdac_shifter #(.ADDR_W(ADDR_W), .GAP_W(GAP_W), .CODE_W(CODE_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_i    (din_s),
        .addr_o   (wr_addr),
        .code_o   (wr_code),
        .dout_o   (ser_dout)
    );

    qdac_chan_bank #(.CODE_W(CODE_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .preset_n (preset_n),
        .half_sel (half_sel),
        .wr_en    (commit),
        .wr_addr  (wr_addr),
        .wr_code  (wr_code),
        .load_n   (load_s),
        .in_flat  (in_flat),
        .dac_flat (dac_codes)
    );
endmodule

// File: rtl/qdac_front_chk.sv
// Property checker for qdac_serial_front, attached with bind below.
module qdac_front_chk #(
    parameter int CODE_W = 14,
    parameter int NUM_CH = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     preset_n,
    input logic                     half_sel,
    input logic                     shift_en,
    input logic                     commit,
    input logic                     load_s,
    input logic                     ser_dout,
    input logic [NUM_CH*CODE_W-1:0] in_flat,
    input logic [NUM_CH*CODE_W-1:0] dac_flat
);
    logic [CODE_W-1:0] exp_pv;
    assign exp_pv = half_sel ? (CODE_W'(1) << (CODE_W-1)) : '0;

    logic [NUM_CH-1:0] chg;
    logic [NUM_CH*CODE_W-1:0] in_prev;
    always_ff @(posedge clk) in_prev <= in_flat;
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chg
        assign chg[c] = in_flat[c*CODE_W +: CODE_W] != in_prev[c*CODE_W +: CODE_W];
    end

    // R7
    preset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!preset_n && $stable(half_sel)) |-> (dac_flat == {NUM_CH{exp_pv}}));

    // R5
    load_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && $past(preset_n) && $past(rst_n) && $past(load_s)) |-> $stable(dac_flat));

    // R6
    load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && $past(preset_n) && $past(rst_n) && !$past(load_s)) |-> (dac_flat == $past(in_flat)));

    // R11
    single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (preset_n && $past(preset_n) && $past(rst_n)) |-> ($countones(chg) <= 1 && (chg == '0 || $past(commit))));

    // R3
    dout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(shift_en)) |-> $stable(ser_dout));
endmodule

bind qdac_serial_front qdac_front_chk #(.CODE_W(CODE_W), .NUM_CH(NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .preset_n (preset_n),
    .half_sel (half_sel),
    .shift_en (shift_en),
    .commit   (commit),
    .load_s   (load_s),
    .ser_dout (ser_dout),
    .in_flat  (in_flat),
    .dac_flat (dac_codes)
);

// File: tb/qdac_serial_front_tb.sv
// Self-checking bench: drives frames, loads and presets, and compares all
// converter outputs against a bench-side model of the registers.
module qdac_serial_front_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 14;
    localparam int NC = 4;

    logic clk = 1'b0;
    logic rst_n, preset_n, half_sel, ser_clk, ser_csn, ser_din, load_n;
    logic ser_dout;
    logic [NC*CW-1:0] dac_codes;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [17:0]   sr_m;
    logic [CW-1:0] in_m  [NC];
    logic [CW-1:0] dac_m [NC];

    always #(CLK_PERIOD/2) clk = ~clk;

    qdac_serial_front dut_i (
        .clk(clk), .rst_n(rst_n), .preset_n(preset_n), .half_sel(half_sel),
        .ser_clk(ser_clk), .ser_csn(ser_csn), .ser_din(ser_din), .load_n(load_n),
        .ser_dout(ser_dout), .dac_codes(dac_codes)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic follow_model();
        if (!load_n) for (int c = 0; c < NC; c++) dac_m[c] = in_m[c];
    endtask

    task automatic set_preset_model(input logic half);
        for (int c = 0; c < NC; c++) begin
            in_m[c]  = half ? 14'h2000 : 14'h0000;
            dac_m[c] = in_m[c];
        end
    endtask

    task automatic check_dacs(input string tag);
        for (int c = 0; c < NC; c++) begin
            vectors++;
            if (dac_codes[c*CW +: CW] !== dac_m[c]) begin
                fails++;
                $display("FAIL %s ch%0d: got %h expected %h", tag, c, dac_codes[c*CW +: CW], dac_m[c]);
            end
        end
    endtask

    task automatic check_dout(input string tag);
        vectors++;
        if (ser_dout !== sr_m[17]) begin
            fails++;
            $display("FAIL %s dout: got %b expected %b", tag, ser_dout, sr_m[17]);
        end
    endtask

    task automatic sbit(input logic b);
        ser_din = b;
        wait_n(4);
        ser_clk = 1'b1;
        wait_n(4);
        if (!ser_csn) sr_m = {sr_m[16:0], b};
        ser_clk = 1'b0;
        if (!ser_csn) check_dout("R8");
    endtask

    task automatic cs_low();
        ser_csn = 1'b0;
        wait_n(4);
    endtask

    task automatic cs_high();
        wait_n(2);
        ser_csn = 1'b1;
        wait_n(6);
        in_m[sr_m[17:16]] = sr_m[13:0];
        follow_model();
    endtask

    task automatic send_bits(input logic [31:0] v, input int n);
        cs_low();
        for (int i = n - 1; i >= 0; i--) sbit(v[i]);
        cs_high();
    endtask

    task automatic pulse_load();
        load_n = 1'b0;
        wait_n(5);
        for (int c = 0; c < NC; c++) dac_m[c] = in_m[c];
        load_n = 1'b1;
        wait_n(4);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; preset_n = 1'b1; half_sel = 1'b1;
        ser_clk = 1'b0; ser_csn = 1'b1; ser_din = 1'b0; load_n = 1'b1;
        sr_m = '0;
        wait_n(6);
        rst_n = 1'b1;
        wait_n(2);
        // R1: half-scale after reset, dout low
        set_preset_model(1'b1);
        check_dacs("R1 half");
        check_dout("R1");
        rst_n = 1'b0; half_sel = 1'b0;
        wait_n(6);
        rst_n = 1'b1;
        wait_n(2);
        set_preset_model(1'b0);
        check_dacs("R1 zero");

        // R2, R5, R11: sweep channels and codes, load held high then pulsed
        for (int ch = 0; ch < NC; ch++) begin
            for (int k = 0; k < 6; k++) begin
                logic [CW-1:0] code;
                code = (k == 0) ? 14'h3FFF : (k == 1) ? 14'h0000 :
                       CW'((k * 32'h0ABC + ch * 32'h0777 + 32'h0101) & 32'h3FFF);
                send_bits({14'd0, ch[1:0], k[1:0], code}, 18);
                check_dacs("R5 hold");
                pulse_load();
                check_dacs("R2 decode");
            end
        end

        // R4: 25-bit burst, upper 7 bits must be ignored
        send_bits({7'd0, 7'b1010111, 2'b10, 2'b01, 14'h1234}, 25);
        pulse_load();
        check_dacs("R4 long frame");

        // R3: serial clock toggles with select high, then R9 partial frame
        for (int i = 0; i < 20; i++) sbit(i[0]);
        check_dout("R3");
        send_bits(32'h5, 4);
        pulse_load();
        check_dacs("R9 short frame");
        check_dacs("R3 no shift when deselected");

        // R8: dedicated pattern, then shifted through
        send_bits({14'd0, 2'b01, 2'b11, 14'h2A5C}, 18);
        send_bits({14'd0, 2'b11, 2'b00, 14'h0F0F}, 18);
        pulse_load();
        check_dacs("R8 chain");

        // R6: load held low, commit and transfer in the same window
        load_n = 1'b0;
        wait_n(5);
        follow_model();
        for (int ch = 0; ch < NC; ch++) begin
            send_bits({14'd0, ch[1:0], 2'b00, CW'(14'h0321 + ch * 14'h0404)}, 18);
            check_dacs("R6 transparent");
        end
        load_n = 1'b1;
        wait_n(4);

        // R10: load pulse in the middle of a frame
        send_bits({14'd0, 2'b10, 2'b00, 14'h3333}, 18);
        begin
            logic [17:0] f;
            f = {2'b00, 2'b01, 14'h1C1C};
            cs_low();
            for (int i = 17; i >= 9; i--) sbit(f[i]);
            pulse_load();
            check_dacs("R10 mid-frame load");
            for (int i = 8; i >= 0; i--) sbit(f[i]);
            cs_high();
            pulse_load();
            check_dacs("R10 frame intact");
        end

        // R7: asynchronous preset, both values, then hold after release
        half_sel = 1'b1;
        @(posedge clk); #2;
        preset_n = 1'b0;
        #1;
        set_preset_model(1'b1);
        check_dacs("R7 async half");
        wait_n(3);
        preset_n = 1'b1;
        wait_n(3);
        check_dacs("R7 hold half");
        pulse_load();
        check_dacs("R7 hold after load");
        half_sel = 1'b0;
        @(posedge clk); #2;
        preset_n = 1'b0;
        #1;
        set_preset_model(1'b0);
        check_dacs("R7 async zero");
        wait_n(3);
        preset_n = 1'b1;
        wait_n(3);
        send_bits({14'd0, 2'b11, 2'b10, 14'h1F00}, 18);
        check_dacs("R7 zero held");
        pulse_load();
        check_dacs("R7 write then load");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule